// File: doc/BRIEF.md
# Transceiver Enable Sequencer

This block steps a radio transceiver through its operating states: an idle state with the synthesizers off, a timed synthesizer-load state, a ready state with both synthesizers running, and the active states for receive, transmit and full-duplex operation. A timed flush state sits between every active state and the next stable state. A register interface supplies the commands as levels: a control enable, a force-alert request, receive and transmit on requests, a duplex mode select, and a choice of where to return after an active state. The calibration logic supplies two status flags, and a free-running tick at one sixty-fourth of the converter clock times the flush.

The sequencer allows only legal moves. It will not enter an active state while either synthesizer is uncalibrated. In half-duplex mode it never switches directly between receive and transmit. In full-duplex mode it ignores the receive request. It discards any request that is raised and dropped again while it sits in one of the two timed states. Requests are read only in stable states, so a request that is still held when a timed state ends is acted on in the next cycle.

Top module: `trx_mode_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and all four enable outputs are low. State codes are: 0 idle, 1 synth-load, 2 ready, 3 receive, 4 transmit, 5 full-duplex, 6 flush.
- R2: While `reg_ctrl_en` is low, no request moves the machine out of a stable state (idle, ready, receive, transmit, full-duplex).
- R3: In idle with `reg_ctrl_en` and `cmd_alert` high, the next state is synth-load. Synth-load lasts `load_delay`+1 cycles and then moves to ready. Both synthesizer enables are high in every state except idle, and they rise only when synth-load is entered.
- R4: Ready moves to an active state only when both `rx_synth_cal` and `tx_synth_cal` are high. Otherwise it stays in ready.
- R5: In half-duplex mode (`fdd_sel` low), ready with `cmd_rx_on` high moves to receive. In receive, `rx_path_en` is high and `tx_path_en` is low.
- R6: In half-duplex mode, ready with `cmd_tx_on` high moves to transmit. This takes priority over a receive request made at the same time. In transmit, `tx_path_en` is high and `rx_path_en` is low.
- R7: Receive never moves directly to transmit, and transmit never moves directly to receive. An active state is left only through flush, when its own request is cleared. A request still held after flush is then served.
- R8: Flush ends on the sixth cycle in which `flush_tick` is high. Cycles without a tick do not advance it. Both path enables are low during flush.
- R9: When flush ends, the machine goes to idle if `back_to_wait` was high in the cycle it left the active state, and to ready otherwise. In idle, both synthesizer enables are low.
- R10: In full-duplex mode (`fdd_sel` high), a transmit request from ready moves to full-duplex, where both path enables are high. `cmd_rx_on` has no effect there and none in ready.
- R11: A request that is raised and dropped while the machine is in synth-load or flush has no effect: the following stable state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_ctrl_en | input | 1 | Enables register commands |
| cmd_alert | input | 1 | Request to leave idle for ready |
| cmd_rx_on | input | 1 | Receive request (level) |
| cmd_tx_on | input | 1 | Transmit / full-duplex request (level) |
| fdd_sel | input | 1 | 1 = full-duplex mode, 0 = half-duplex |
| back_to_wait | input | 1 | Return to idle instead of ready after an active state |
| rx_synth_cal | input | 1 | Receive synthesizer calibrated |
| tx_synth_cal | input | 1 | Transmit synthesizer calibrated |
| load_delay | input | LD_W | Synth-load duration minus one, in clock cycles |
| flush_tick | input | 1 | Converter clock / 64 tick enable |
| state_o | output | 3 | Current state code |
| rx_synth_en | output | 1 | Receive synthesizer enable |
| tx_synth_en | output | 1 | Transmit synthesizer enable |
| rx_path_en | output | 1 | Receive path enable |
| tx_path_en | output | 1 | Transmit path enable |

## Verification
The assertions check the transition rules on every cycle. These rules are the calibration gate in ready, the ban on moves between the active states other than through flush, flush holding without a tick, full-duplex mode ignoring the receive request, the exits allowed from the timed states, and synthesizer enables rising only at synth-load. The exact lengths of synth-load and flush, the choice of return state, the priority of transmit over receive, and the serving of a request held across a timed state all depend on particular sequences of stimulus. Only the bench's scenarios demonstrate those.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;
    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_ALERT = 3'd2,
        ST_RX    = 3'd3,
        ST_TX    = 3'd4,
        ST_FDD   = 3'd5,
        ST_FLUSH = 3'd6
    } trx_state_e;
endpackage

// File: rtl/trx_seq_gate.sv
module trx_seq_gate (
    input  logic ctrl_en,
    input  logic rx_cal,
    input  logic tx_cal,
    input  logic req_rx,
    input  logic req_tx,
    input  logic fdd,
    output logic go_rx,
    output logic go_tx
);
    logic cal_ok;

    always_comb begin
        cal_ok = rx_cal & tx_cal;
        // transmit wins over receive; receive request is meaningless in FDD
        go_tx  = ctrl_en & cal_ok & req_tx;
        go_rx  = ctrl_en & cal_ok & req_rx & ~req_tx & ~fdd;
    end
endmodule

// File: rtl/trx_seq_outdec.sv
module trx_seq_outdec
    import trx_mode_pkg::*;
(
    input  trx_state_e st,
    output logic       synth_rx,
    output logic       synth_tx,
    output logic       path_rx,
    output logic       path_tx
);
    always_comb begin
        synth_rx = 1'b1;
        synth_tx = 1'b1;
        path_rx  = 1'b0;
        path_tx  = 1'b0;
        unique case (st)
            ST_WAIT: begin
                synth_rx = 1'b0;
                synth_tx = 1'b0;
            end
            ST_RX:  path_rx = 1'b1;
            ST_TX:  path_tx = 1'b1;
            ST_FDD: begin
                path_rx = 1'b1;
                path_tx = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trx_mode_seq.sv
module trx_mode_seq
    import trx_mode_pkg::*;
#(
    parameter int LD_W        = 16,
    parameter int FLUSH_TICKS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_ctrl_en,
    input  logic            cmd_alert,
    input  logic            cmd_rx_on,
    input  logic            cmd_tx_on,
    input  logic            fdd_sel,
    input  logic            back_to_wait,
    input  logic            rx_synth_cal,
    input  logic            tx_synth_cal,
    input  logic [LD_W-1:0] load_delay,
    input  logic            flush_tick,
    output logic [2:0]      state_o,
    output logic            rx_synth_en,
    output logic            tx_synth_en,
    output logic            rx_path_en,
    output logic            tx_path_en
);
    localparam int FL_W  = (FLUSH_TICKS > 1) ? $clog2(FLUSH_TICKS) : 1;
    localparam int CNT_W = (LD_W > FL_W) ? LD_W : FL_W;
    localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_TICKS - 1);

    typedef struct packed {
        trx_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             ret_wait;
    } seq_t;

    seq_t seq_d, seq_q;
    logic go_rx, go_tx;

    trx_seq_gate i_gate (
        .ctrl_en (reg_ctrl_en),
        .rx_cal  (rx_synth_cal),
        .tx_cal  (tx_synth_cal),
        .req_rx  (cmd_rx_on),
        .req_tx  (cmd_tx_on),
        .fdd     (fdd_sel),
        .go_rx   (go_rx),
        .go_tx   (go_tx)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_WAIT: begin
                if (reg_ctrl_en && cmd_alert) begin
                    seq_d.st              = ST_LOAD;
                    seq_d.cnt             = '0;
                    seq_d.cnt[LD_W-1:0]   = load_delay;
                end
            end
            ST_LOAD: begin
                // requests are not looked at here: they are dropped
                if (seq_q.cnt == '0) seq_d.st = ST_ALERT;
                else                 seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            ST_ALERT: begin
                if (go_tx)      seq_d.st = fdd_sel ? ST_FDD : ST_TX;
                else if (go_rx) seq_d.st = ST_RX;
            end
            ST_RX: begin
                if (reg_ctrl_en && !cmd_rx_on) begin
                    seq_d.st       = ST_FLUSH;
                    seq_d.cnt      = '0;
                    seq_d.ret_wait = back_to_wait;
                end
            end
            ST_TX, ST_FDD: begin
                if (reg_ctrl_en && !cmd_tx_on) begin
                    seq_d.st       = ST_FLUSH;
                    seq_d.cnt      = '0;
                    seq_d.ret_wait = back_to_wait;
                end
            end
            ST_FLUSH: begin
                if (flush_tick) begin
                    if (seq_q.cnt == FLUSH_LAST)
                        seq_d.st = seq_q.ret_wait ? ST_WAIT : ST_ALERT;
                    else
                        seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st       <= ST_WAIT;
            seq_q.cnt      <= '0;
            seq_q.ret_wait <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    trx_seq_outdec i_outdec (
        .st       (seq_q.st),
        .synth_rx (rx_synth_en),
        .synth_tx (tx_synth_en),
        .path_rx  (rx_path_en),
        .path_tx  (tx_path_en)
    );

    assign state_o = seq_q.st;
endmodule

// File: rtl/trx_mode_seq_chk.sv
module trx_mode_seq_chk
    import trx_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_ctrl_en,
    input logic       cmd_tx_on,
    input logic       fdd_sel,
    input logic       rx_synth_cal,
    input logic       tx_synth_cal,
    input logic       flush_tick,
    input logic [2:0] state_o,
    input logic       rx_synth_en,
    input logic       tx_synth_en
);
    assert_locked_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_WAIT && !reg_ctrl_en) |=> state_o == ST_WAIT);

    assert_synth_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_synth_en) |-> state_o == ST_LOAD);

    assert_synth_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_synth_en == tx_synth_en);

    assert_load_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOAD) |=> (state_o inside {ST_LOAD, ST_ALERT}));

    assert_cal_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ALERT && !(rx_synth_cal && tx_synth_cal)) |=> state_o == ST_ALERT);

    assert_rx_no_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RX) |=> (state_o inside {ST_RX, ST_FLUSH}));

    assert_tx_no_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_TX) |=> (state_o inside {ST_TX, ST_FLUSH}));

    assert_fdd_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FDD) |=> (state_o inside {ST_FDD, ST_FLUSH}));

    assert_flush_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FLUSH && !flush_tick) |=> state_o == ST_FLUSH);

    assert_flush_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FLUSH) |=> (state_o inside {ST_FLUSH, ST_ALERT, ST_WAIT}));

    assert_fdd_rx_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ALERT && fdd_sel && !cmd_tx_on) |=> state_o == ST_ALERT);
endmodule

bind trx_mode_seq trx_mode_seq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_ctrl_en  (reg_ctrl_en),
    .cmd_tx_on    (cmd_tx_on),
    .fdd_sel      (fdd_sel),
    .rx_synth_cal (rx_synth_cal),
    .tx_synth_cal (tx_synth_cal),
    .flush_tick   (flush_tick),
    .state_o      (state_o),
    .rx_synth_en  (rx_synth_en),
    .tx_synth_en  (tx_synth_en)
);

// File: tb/test_trx_mode_seq.sv
module test_trx_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LD_W       = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_ctrl_en = 1'b0;
    logic            cmd_alert = 1'b0;
    logic            cmd_rx_on = 1'b0;
    logic            cmd_tx_on = 1'b0;
    logic            fdd_sel = 1'b0;
    logic            back_to_wait = 1'b0;
    logic            rx_synth_cal = 1'b1;
    logic            tx_synth_cal = 1'b1;
    logic [LD_W-1:0] load_delay = '0;
    logic            flush_tick = 1'b0;
    logic [2:0]      state_o;
    logic            rx_synth_en, tx_synth_en, rx_path_en, tx_path_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trx_mode_seq #(.LD_W(LD_W), .FLUSH_TICKS(6)) i_trx_mode_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_ctrl_en  (reg_ctrl_en),
        .cmd_alert    (cmd_alert),
        .cmd_rx_on    (cmd_rx_on),
        .cmd_tx_on    (cmd_tx_on),
        .fdd_sel      (fdd_sel),
        .back_to_wait (back_to_wait),
        .rx_synth_cal (rx_synth_cal),
        .tx_synth_cal (tx_synth_cal),
        .load_delay   (load_delay),
        .flush_tick   (flush_tick),
        .state_o      (state_o),
        .rx_synth_en  (rx_synth_en),
        .tx_synth_en  (tx_synth_en),
        .rx_path_en   (rx_path_en),
        .tx_path_en   (tx_path_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            flush_tick = 1'b1;
            step();
            flush_tick = 1'b0;
            step();
        end
    endtask

    task automatic t_reset;
        chk("R1 state", state_o, 0);
        chk("R1 enables", {rx_synth_en, tx_synth_en, rx_path_en, tx_path_en}, 0);
    endtask

    task automatic t_disabled;
        load_delay = 3;
        cmd_alert  = 1'b1;
        step(4);
        chk("R2 idle held while disabled", state_o, 0);
    endtask

    task automatic t_load;
        reg_ctrl_en = 1'b1;
        step();
        chk("R3 enter load", state_o, 1);
        chk("R3 synth on in load", {rx_synth_en, tx_synth_en}, 3);
        cmd_rx_on = 1'b1;                 // R11 pulse during load
        step(2);
        cmd_rx_on = 1'b0;
        step();
        chk("R3 load lasts delay+1", state_o, 1);
        step();
        chk("R3 reach ready", state_o, 2);
        step(2);
        chk("R11 load pulse dropped", state_o, 2);
    endtask

    task automatic t_cal;
        rx_synth_cal = 1'b0;
        cmd_rx_on    = 1'b1;
        step(3);
        chk("R4 rx cal missing", state_o, 2);
        rx_synth_cal = 1'b1;
        tx_synth_cal = 1'b0;
        step(2);
        chk("R4 tx cal missing", state_o, 2);
        tx_synth_cal = 1'b1;
        step();
        chk("R5 enter receive", state_o, 3);
        chk("R5 paths", {rx_path_en, tx_path_en}, 2);
    endtask

    task automatic t_nohop;
        cmd_tx_on = 1'b1;
        step(3);
        chk("R7 no rx to tx", state_o, 3);
        cmd_rx_on    = 1'b0;
        back_to_wait = 1'b0;
        step();
        chk("R7 rx exits to flush", state_o, 6);
        chk("R8 paths off in flush", {rx_path_en, tx_path_en}, 0);
        step(3);
        chk("R8 no tick no advance", state_o, 6);
        ticks(5);
        chk("R8 five ticks still flush", state_o, 6);
        flush_tick = 1'b1;
        step();
        flush_tick = 1'b0;
        chk("R9 return to ready", state_o, 2);
        step();
        chk("R7 held tx served after flush", state_o, 4);
        chk("R6 paths", {rx_path_en, tx_path_en}, 1);
    endtask

    task automatic t_flush_drop;
        cmd_rx_on = 1'b1;
        step(2);
        chk("R7 no tx to rx", state_o, 4);
        cmd_rx_on = 1'b0;
        cmd_tx_on = 1'b0;
        step();
        chk("R7 tx exits to flush", state_o, 6);
        cmd_tx_on = 1'b1;                 // R11 pulse during flush
        step();
        cmd_tx_on = 1'b0;
        ticks(6);
        chk("R8 six ticks end flush", state_o, 2);
        step(2);
        chk("R11 flush pulse dropped", state_o, 2);
    endtask

    task automatic t_priority;
        cmd_rx_on = 1'b1;
        cmd_tx_on = 1'b1;
        step();
        chk("R6 tx over rx", state_o, 4);
        cmd_rx_on    = 1'b0;
        cmd_tx_on    = 1'b0;
        cmd_alert    = 1'b0;
        back_to_wait = 1'b1;
        step();
        back_to_wait = 1'b0;              // value captured at exit counts
        ticks(6);
        chk("R9 return to idle", state_o, 0);
        chk("R9 synth off", {rx_synth_en, tx_synth_en}, 0);
    endtask

    task automatic t_fdd;
        load_delay = 0;
        cmd_alert  = 1'b1;
        step();
        chk("R3 zero delay load", state_o, 1);
        step();
        chk("R3 zero delay ready", state_o, 2);
        fdd_sel   = 1'b1;
        cmd_rx_on = 1'b1;
        step(3);
        chk("R10 rx ignored in fdd ready", state_o, 2);
        cmd_tx_on = 1'b1;
        step();
        chk("R10 enter fdd", state_o, 5);
        chk("R10 both paths", {rx_path_en, tx_path_en}, 3);
        cmd_rx_on = 1'b0;
        step(2);
        chk("R10 rx drop no effect", state_o, 5);
        reg_ctrl_en = 1'b0;
        cmd_tx_on   = 1'b0;
        step(2);
        chk("R2 fdd held while disabled", state_o, 5);
        reg_ctrl_en = 1'b1;
        step();
        chk("R7 fdd exits to flush", state_o, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_disabled();
        t_load();
        t_cal();
        t_nohop();
        t_flush_drop();
        t_priority();
        t_fdd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule